// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling

This block turns a serial RxD line into characters. It samples the line on a 16x oversampling enable that the surrounding logic supplies. Characters carry 5 to 8 data bits, an optional parity bit with even or odd sense, and one stop bit. Each finished character is written into a 16-entry receive queue. Its parity error, framing error, break and overrun flags are stored with it. The host pops entries one at a time. The data and flag outputs always describe the entry at the head of the queue.

Three line conditions get special handling:

- **False starts.** A low pulse that is gone by mid start bit is dropped.
- **Framing errors.** After a framing error on a nonzero character, reception restarts half a bit later if the line is still low.
- **Breaks.** A line held low for a whole character yields one all-zero entry marked as a break. The receiver then waits for a clean, two-sample high before it looks for a new start.

The line passes through a two-flop synchronizer before any decision is made.

Top module: `uart_rx_brk`

## Requirements
- R1: While `rx_en` is high, a start is detected on a tick where the synchronized line is low and was high on the previous tick. While `rx_en` is low, line activity produces no entries.
- R2: Seven ticks after the detected edge, the line is sampled again. If it is high, the start is dropped, nothing is stored, and the edge search resumes.
- R3: After a valid start, samples are taken every 16 ticks, least significant bit first. The data width is `char_len`+5 (0 gives 5 bits, 3 gives 8 bits). Unused upper bits of `rd_data` read as zero.
- R4: When `par_en` is 1, one parity bit follows the data. `par_odd`=1 selects odd parity and 0 selects even parity. A mismatch sets `st_par_err` on that entry.
- R5: A high stop sample stores the character with no framing flag, and the edge search resumes at once.
- R6: A low stop sample on a character that is not all zero stores it with `st_frm_err`=1. If the line is still low 8 ticks after the stop sample, that tick is taken as a new start edge.
- R7: If the data bits, the parity bit (when enabled) and the stop bit are all low, exactly one entry is stored. That entry has data 0, `st_brk`=1, `st_frm_err`=0 and `st_par_err`=0.
- R8: After a break, the start search resumes only once the synchronized line has been high on two consecutive clock edges. A one-cycle high pulse does not end the break.
- R9: Entries leave the queue in arrival order. `rx_rdy` is high while the queue is not empty. The data and flag outputs describe the head entry and read as 0 when the queue is empty.
- R10: The queue holds 16 entries. A character that arrives while the queue is full is discarded, and the overrun flag is set on the newest stored entry.
- R11: `rd_pop` removes the head entry on a clock edge where `rx_rdy` is high. A pop while the queue is empty has no effect.
- R12: After reset, `rx_rdy` and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Asynchronous serial line, idle high |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_pop | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry data |
| rx_rdy | output | 1 | Queue not empty |
| st_par_err | output | 1 | Head entry parity error |
| st_frm_err | output | 1 | Head entry framing error |
| st_brk | output | 1 | Head entry is a break |
| st_ovr_err | output | 1 | Overrun followed the head entry |

## Verification
Some rules are checked on every cycle:

- A dropped start always coincides with a high line sample.
- A break is only left after two high samples in a row.
- Break entries are always zero with no framing flag, and stored data never has bits set above the character width.
- Queue occupancy moves exactly as pushes and pops allow, and pops on an empty queue change nothing.

Other behaviour shows only in the bench scenarios:

- The bit-center sample timing.
- The half-bit restart after a framing error, since a missed restart only shows up as a lost following character.
- Parity sense.
- Which entry receives the overrun flag.
- Whether a one-cycle glitch ends a break.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HALF, S_BRK
  } rx_st_t;
endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rxb_deser.sv
module rxb_deser
  import rxb_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       push,
  output rx_char_t   push_ent
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] C_START = CW'(OSR/2 - 2);
  localparam logic [CW-1:0] C_HALF  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] C_BIT   = CW'(OSR - 1);

  rx_st_t            st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d, last_q, last_d, hi_q, hi_d;
  logic [2:0]        last_idx;
  logic [CHAR_W-1:0] data_al;
  logic              perr, samp;

  always_comb begin
    last_idx = {1'b1, char_len};
    data_al  = sh_q >> (2'd3 - char_len);
    perr     = par_en & (^data_al ^ pbit_q ^ par_odd);
    samp     = tick && (cnt_q == C_BIT);
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q;
    pbit_d = pbit_q; last_d = last_q; hi_d = hi_q;
    push = 1'b0; push_ent = '0;
    if (!en) begin
      st_d = S_IDLE; last_d = rxd_s;
    end else begin
      if (tick && st_q != S_BRK && st_q != S_IDLE && !samp &&
          !(st_q == S_START && cnt_q == C_START) && !(st_q == S_HALF && cnt_q == C_HALF))
        cnt_d = cnt_q + 1'b1;
      case (st_q)
        S_IDLE: if (tick) begin
          last_d = rxd_s;
          if (last_q && !rxd_s) begin st_d = S_START; cnt_d = '0; end
        end
        S_START: if (tick && cnt_q == C_START) begin
          if (rxd_s) begin st_d = S_IDLE; last_d = 1'b1; end
          else begin st_d = S_DATA; cnt_d = '0; bit_d = '0; sh_d = '0; end
        end
        S_DATA: if (samp) begin
          cnt_d = '0;
          sh_d  = {rxd_s, sh_q[CHAR_W-1:1]};
          if (bit_q == last_idx) st_d = par_en ? S_PAR : S_STOP;
          else                   bit_d = bit_q + 1'b1;
        end
        S_PAR: if (samp) begin
          cnt_d = '0; pbit_d = rxd_s; st_d = S_STOP;
        end
        S_STOP: if (samp) begin
          cnt_d = '0;
          push  = 1'b1;
          push_ent.data = data_al;
          if (rxd_s) begin
            push_ent.par = perr; st_d = S_IDLE; last_d = 1'b1;
          end else if (data_al == '0 && !(par_en && pbit_q)) begin
            push_ent.brk = 1'b1; st_d = S_BRK; hi_d = 1'b0;
          end else begin
            push_ent.par = perr; push_ent.frm = 1'b1;
            if (data_al != '0) st_d = S_HALF;
            else begin st_d = S_IDLE; last_d = 1'b0; end
          end
        end
        S_HALF: if (tick && cnt_q == C_HALF) begin
          cnt_d = '0;
          if (!rxd_s) st_d = S_START;
          else begin st_d = S_IDLE; last_d = 1'b1; end
        end
        S_BRK: begin
          hi_d = rxd_s;
          if (rxd_s && hi_q) begin st_d = S_IDLE; last_d = 1'b1; end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
      pbit_q <= 1'b0; last_q <= 1'b1; hi_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d;
      pbit_q <= pbit_d; last_q <= last_d; hi_q <= hi_d;
    end

  // R2
  start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_START && st_q == S_IDLE && $past(en)) |-> $past(rxd_s));
  // R8
  brk_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_BRK && st_q == S_IDLE && $past(en)) |-> ($past(rxd_s) && $past(rxd_s, 2)));
  // R7
  brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_ent.brk) |-> (push_ent.data == '0 && !push_ent.frm && !push_ent.par));
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (((push_ent.data >> char_len) >> 5) == '0 && tick));
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo
  import rxb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_char_t wr_ent,
  input  logic     pop,
  output rx_char_t head,
  output logic     head_ovr,
  output logic     empty
);
  localparam int AW = $clog2(DEPTH);

  rx_char_t         mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic [DEPTH-1:0] ovr_q, ovr_d;
  logic             full, wr_ok, rd_ok;

  always_comb begin
    full  = (cnt_q == (AW+1)'(DEPTH));
    empty = (cnt_q == '0);
    wr_ok = push && !full;
    rd_ok = pop && !empty;
    wp_d  = wp_q + AW'(wr_ok);
    rp_d  = rp_q + AW'(rd_ok);
    cnt_d = cnt_q + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
    ovr_d = ovr_q;
    if (wr_ok)             ovr_d[wp_q] = 1'b0;
    else if (push && full) ovr_d[wp_q - AW'(1)] = 1'b1;
  end

  always_ff @(posedge clk)
    if (wr_ok) mem[wp_q] <= wr_ent;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; ovr_q <= '0;
    end else begin
      wp_q <= wp_d; rp_q <= rp_d; cnt_q <= cnt_d; ovr_q <= ovr_d;
    end

  assign head     = mem[rp_q];
  assign head_ovr = ovr_q[rp_q];

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q) && wp_q == $past(wp_q)));
  // R11
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && rp_q == $past(rp_q)));
  // R9
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import rxb_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_en,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       rx_rdy,
  output logic       st_par_err,
  output logic       st_frm_err,
  output logic       st_brk,
  output logic       st_ovr_err
);
  logic [1:0] rs_q;
  logic       rst_ns, rxd_s, push, empty, head_ovr;
  rx_char_t   push_ent, head;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_ns = rs_q[1];

  rxb_sync #(.STAGES(2), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_ns), .d(rxd), .q(rxd_s));

  rxb_deser #(.OSR(OSR)) i_deser (
    .clk(clk), .rst_n(rst_ns), .en(rx_en), .tick(tick16), .rxd_s(rxd_s),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .push(push), .push_ent(push_ent));

  rxb_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_ns), .push(push), .wr_ent(push_ent), .pop(rd_pop),
    .head(head), .head_ovr(head_ovr), .empty(empty));

  always_comb begin
    rx_rdy     = !empty;
    rd_data    = empty ? 8'h00 : head.data;
    st_par_err = !empty && head.par;
    st_frm_err = !empty && head.frm;
    st_brk     = !empty && head.brk;
    st_ovr_err = !empty && head_ovr;
  end
endmodule

// File: tb/test_uart_rx_brk.sv
module test_uart_rx_brk;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx_en = 1'b0, rxd = 1'b1;
  logic [1:0] char_len = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0, rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic rx_rdy, st_par_err, st_frm_err, st_brk, st_ovr_err;
  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b1, done = 1'b0;
  logic [11:0] exp_q[$];

  always #10 clk = ~clk;

  uart_rx_brk i_uart_rx_brk (.*);

  initial begin : tick_gen
    int div = 0;
    forever begin
      @(negedge clk);
      tick16 <= (div == 3);
      div = (div + 1) % 4;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (tick16) k++;
    end
  endtask

  // one frame; expectation pushed before the design can store it
  task automatic send(logic [7:0] d0, logic [1:0] len, logic pe, logic odd,
                      logic badp, logic stopb, logic eovr, logic expect_it);
    logic [7:0] d;
    d = d0 & (8'hFF >> (2'd3 - len));
    char_len = len; par_en = pe; par_odd = odd;
    if (expect_it)
      exp_q.push_back({eovr, 1'b0, (~stopb) & (d != 0), pe & badp, d});
    rxd = 1'b0; ticks(16);
    for (int i = 0; i <= int'(len) + 4; i++) begin rxd = d[i]; ticks(16); end
    if (pe) begin rxd = ^d ^ odd ^ badp; ticks(16); end
    rxd = stopb; ticks(16);
  endtask

  task automatic idle(int n);
    rxd = 1'b1; ticks(n);
  endtask

  task automatic drain;
    int t = 0;
    while (exp_q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      rd_pop <= 1'b0;
      if (mon_on && rx_rdy) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9: actual=unexpected entry %0h expected=none", rd_data);
        end else begin
          check("R9 head entry", {st_ovr_err, st_brk, st_frm_err, st_par_err, rd_data},
                exp_q.pop_front());
        end
        rd_pop <= 1'b1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 rdy/flags", {rx_rdy, st_par_err, st_frm_err, st_brk, st_ovr_err}, 0);
    rx_en = 1'b1;
    idle(32);
    // R3 R5 8-bit, back to back
    send(8'hA5, 2'd3, 0, 0, 0, 1, 0, 1);
    send(8'h3C, 2'd3, 0, 0, 0, 1, 0, 1);
    idle(16);
    // R3 5-bit upper zero
    send(8'hF5, 2'd0, 0, 0, 0, 1, 0, 1); idle(16);
    // R4 even good, odd good, odd bad
    send(8'h5B, 2'd2, 1, 0, 0, 1, 0, 1); idle(8);
    send(8'h5B, 2'd2, 1, 1, 0, 1, 0, 1); idle(8);
    send(8'hC3, 2'd3, 1, 1, 1, 1, 0, 1); idle(16);
    drain();
    // R2 false start
    rxd = 1'b0; ticks(4); idle(48);
    check("R2 false start dropped", rx_rdy, 0);
    send(8'h81, 2'd3, 0, 0, 0, 1, 0, 1); idle(16);
    drain();
    // R1 disabled receiver ignores line
    rx_en = 1'b0;
    send(8'h77, 2'd3, 0, 0, 0, 1, 0, 0); idle(32);
    check("R1 disabled no entry", rx_rdy, 0);
    rx_en = 1'b1; idle(16);
    // R6 framing error then low line restarts half a bit later
    send(8'h55, 2'd3, 0, 0, 0, 0, 0, 1);
    send(8'h96, 2'd3, 0, 0, 0, 1, 0, 1);
    idle(32);
    drain();
    check("R6 both frames stored", exp_q.size(), 0);
    // R7 break with glitch, R8 end of break
    exp_q.push_back({4'b0100, 8'h00});
    rxd = 1'b0; ticks(16 * 12);
    @(negedge clk) rxd = 1'b1;
    @(negedge clk) rxd = 1'b0;
    ticks(32);
    idle(16);
    send(8'h42, 2'd3, 0, 0, 0, 1, 0, 1); idle(16);
    drain();
    check("R8 single break entry", exp_q.size(), 0);
    // R10 overrun
    mon_on = 1'b0;
    for (int i = 0; i < 17; i++) begin
      send(8'(i * 7 + 1), 2'd3, 0, 0, 0, 1, (i == 15), (i < 16));
      idle(4);
    end
    idle(16);
    check("R10 head no overrun", {rx_rdy, st_ovr_err, rd_data}, {2'b10, 8'h01});
    // R11 data held without pop
    check("R11 held head", rd_data, 8'h01);
    mon_on = 1'b1;
    drain();
    idle(16);
    check("R10 all drained", exp_q.size(), 0);
    check("R9 empty outputs", {rx_rdy, st_ovr_err, rd_data}, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule